// File: doc/BRIEF.md
# Paired Stub Packet Framer

This block takes stubs from two independent front-end concentrators, called side A and side B, and builds a stream of 64-bit frames. Each frame carries one stub from each side. Time is divided into windows of 64 clock cycles, which at the 320 MHz frame clock span eight bunch crossings. Every stub that arrives during a window is buffered. The whole set for that window is then sent as one packet during the next window. A packet is 58 data frames followed by 6 idle gap frames.

The number of stubs kept for each side in one window is capped by a speed setting. The slow setting keeps 16 stubs per side and the fast setting keeps 35. Stubs past the cap are discarded and counted in a saturating counter. When one side has fewer stubs than the other, the empty half of the frame is filled with zeros and its valid bit is clear. Data frames that neither side uses go out as all-zero padding, still marked as data.

Top module: `stub_pair_framer`

## Requirements
- R1: Frame layout: bit 63 is the side A valid flag, bits 62:32 carry the side A stub, bit 31 is the side B valid flag, and bits 30:0 carry the side B stub.
- R2: After the first packet starts, the output repeats a 64-cycle cadence: `frame_valid` is high for 58 consecutive cycles and then low for 6 cycles. `frame_data` is all zero whenever `frame_valid` is low.
- R3: `frame_sop` is high only on the first data frame of each packet, and never without `frame_valid`.
- R4: The stubs one side delivers within a 64-cycle window fill that side's half of the next packet in arrival order. The k-th accepted stub goes into data frame k, counting from 0. The two sides are independent of each other.
- R5: With the slow setting (`fast_mode` = 0), only the first 16 stubs per side in a window are kept.
- R6: With the fast setting (`fast_mode` = 1), only the first 35 stubs per side in a window are kept.
- R7: `fast_mode` is sampled in the last cycle of the previous window, or during reset for the first window. It then applies to the whole next window, so a change between windows takes effect cleanly.
- R8: A half with no stub has both its valid bit and its stub field at zero. Data frames past both sides' counts are all-zero padding with `frame_valid` high.
- R9: `drop_count` goes up by the number of stubs discarded in a cycle (0, 1 or 2), one cycle later. It saturates at its maximum and never goes down until reset.
- R10: While reset is held and right after it, all outputs are zero. No data frame is sent during the first window, because no window has completed yet.
- R11: Window w is counted from 0, starting with the first rising edge with reset low. Its `frame_sop` is visible after rising edge 64(w+1)+1, which is two register stages after the read of its first slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_mode | input | 1 | Speed setting: 0 keeps 16 stubs per side, 1 keeps 35 |
| a_valid | input | 1 | Side A stub present this cycle |
| a_stub | input | STUB_W | Side A stub payload |
| b_valid | input | 1 | Side B stub present this cycle |
| b_stub | input | STUB_W | Side B stub payload |
| frame_valid | output | 1 | Data frame present (low in gap frames) |
| frame_sop | output | 1 | First data frame of a packet |
| frame_data | output | 2*(STUB_W+1) | Side A half on top, side B half below |
| drop_count | output | CNT_W | Saturating count of discarded stubs |

## Verification
The bench builds the framer with the default frame and limit parameters but narrows `CNT_W` to 6. The early directed windows then push the discard total past 63, so both the counting and the saturation of `drop_count` can be observed in a short run. The directed windows place stub counts exactly at the limits and one past them in both speed settings. They also cover one-sided and empty windows and a setting change between windows. Random windows then mix densities and settings, and every output cycle is compared against a model of the window buffers.

// File: rtl/framer_pkg.sv
package framer_pkg;

  typedef enum logic {
    SPEED_SLOW = 1'b0,
    SPEED_FAST = 1'b1
  } speed_e;

  localparam int SIDES = 2;

endpackage

// File: rtl/pkt_sequencer.sv
module pkt_sequencer
  import framer_pkg::*;
#(
  parameter int DATA_FRAMES = 58,
  parameter int GAP_FRAMES  = 6,
  parameter int LIM_SLOW    = 16,
  parameter int LIM_FAST    = 35,
  localparam int PKT_LEN    = DATA_FRAMES + GAP_FRAMES,
  localparam int PH_W       = $clog2(PKT_LEN),
  localparam int CW         = $clog2(LIM_FAST + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fast_mode,
  output logic [PH_W-1:0] phase,
  output logic            win_end,
  output logic            wr_bank,
  output logic            data_slot,
  output logic [CW-1:0]   lim
);

  speed_e mode_q;
  logic   primed;

  assign win_end   = (phase == PH_W'(PKT_LEN - 1));
  assign data_slot = primed && (phase < PH_W'(DATA_FRAMES));
  assign lim       = (mode_q == SPEED_FAST) ? CW'(LIM_FAST) : CW'(LIM_SLOW);

  // Window clock: phase counter, bank select, first-window suppression.
  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= '0;
      wr_bank <= 1'b0;
      primed  <= 1'b0;
      mode_q  <= speed_e'(fast_mode);
    end else begin
      phase <= win_end ? '0 : phase + PH_W'(1);
      if (win_end) begin
        wr_bank <= ~wr_bank;
        primed  <= 1'b1;
        mode_q  <= speed_e'(fast_mode);
      end
    end
  end

  // R2: the window counter always restarts after its last phase
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (phase == '0));

  // R4: buffers swap roles exactly at each window end
  p_bank_flip_r4: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (wr_bank != $past(wr_bank)));

  // R7: the speed setting only moves at a window boundary
  p_mode_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(win_end) |-> $stable(lim));

endmodule

// File: rtl/side_buffer.sv
module side_buffer #(
  parameter int STUB_W = 31,
  parameter int CW     = 6,
  parameter int PH_W   = 6,
  parameter int LIM_FAST = 35,
  localparam int DEPTH = 2 ** (CW + 1),
  localparam int XW    = (PH_W > CW) ? PH_W : CW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [STUB_W-1:0] in_stub,
  input  logic [CW-1:0]     lim,
  input  logic              win_end,
  input  logic              wr_bank,
  input  logic [PH_W-1:0]   phase,
  output logic              drop,
  output logic              slot_hit,
  output logic [STUB_W-1:0] stub_q
);

  logic [STUB_W-1:0] mem [DEPTH];
  logic [CW-1:0]     wcnt;
  logic [CW-1:0]     rcnt;
  logic              accept;
  logic [CW:0]       wr_addr;
  logic [CW:0]       rd_addr;

  assign accept  = in_valid && (wcnt < lim);
  assign drop    = in_valid && !accept;
  assign wr_addr = {wr_bank, wcnt};
  assign rd_addr = {~wr_bank, CW'(phase)};

  // Two banks in one simple dual-port array: one fills, the other drains.
  always_ff @(posedge clk) begin
    if (accept) mem[wr_addr] <= in_stub;
  end

  always_ff @(posedge clk) begin
    stub_q <= mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt     <= '0;
      rcnt     <= '0;
      slot_hit <= 1'b0;
    end else begin
      slot_hit <= (XW'(phase) < XW'(rcnt));
      if (win_end) begin
        rcnt <= wcnt + CW'(accept);
        wcnt <= '0;
      end else if (accept) begin
        wcnt <= wcnt + CW'(1);
      end
    end
  end

  // R5/R6: the fill level never passes the limit of the current window
  p_fill_bound_r5: assert property (@(posedge clk) disable iff (rst)
    wcnt <= lim);

  // R6: the drained count never passes the fast limit
  p_rcnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rcnt <= CW'(LIM_FAST));

  // R9: a discarded stub leaves the fill level unchanged
  p_drop_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (drop && !win_end) |=> $stable(wcnt));

endmodule

// File: rtl/drop_counter.sv
module drop_counter #(
  parameter int N_IN  = 2,
  parameter int CNT_W = 16,
  localparam int IW   = $clog2(N_IN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_IN-1:0]  drop,
  output logic [CNT_W-1:0] count
);

  logic [IW-1:0]  inc;
  logic [CNT_W:0] sum;

  always_comb begin
    inc = '0;
    for (int i = 0; i < N_IN; i++) begin
      inc = inc + IW'(drop[i]);
    end
    sum = {1'b0, count} + (CNT_W + 1)'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
  end

  // R9: the count never goes down outside reset
  p_count_mono_r9: assert property (@(posedge clk) disable iff (rst)
    ##1 count >= $past(count));

  // R9: no discard means no change
  p_count_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (drop == '0) |=> $stable(count));

endmodule

// File: rtl/stub_pair_framer.sv
module stub_pair_framer
  import framer_pkg::*;
#(
  parameter int STUB_W      = 31,
  parameter int DATA_FRAMES = 58,
  parameter int GAP_FRAMES  = 6,
  parameter int LIM_SLOW    = 16,
  parameter int LIM_FAST    = 35,
  parameter int CNT_W       = 16,
  localparam int HALF_W     = STUB_W + 1,
  localparam int FRAME_W    = 2 * HALF_W,
  localparam int PKT_LEN    = DATA_FRAMES + GAP_FRAMES,
  localparam int PH_W       = $clog2(PKT_LEN),
  localparam int CW         = $clog2(LIM_FAST + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fast_mode,
  input  logic               a_valid,
  input  logic [STUB_W-1:0]  a_stub,
  input  logic               b_valid,
  input  logic [STUB_W-1:0]  b_stub,
  output logic               frame_valid,
  output logic               frame_sop,
  output logic [FRAME_W-1:0] frame_data,
  output logic [CNT_W-1:0]   drop_count
);

  logic [PH_W-1:0]   phase;
  logic              win_end;
  logic              wr_bank;
  logic              data_slot;
  logic [CW-1:0]     lim;
  logic [SIDES-1:0]  in_v;
  logic [STUB_W-1:0] in_s   [SIDES];
  logic [SIDES-1:0]  drop;
  logic [SIDES-1:0]  hit;
  logic [STUB_W-1:0] stub_q [SIDES];
  logic [HALF_W-1:0] half_d [SIDES];
  logic              dslot_q;
  logic              sop_q;

  assign in_v    = {b_valid, a_valid};
  assign in_s[0] = a_stub;
  assign in_s[1] = b_stub;

  pkt_sequencer #(
    .DATA_FRAMES(DATA_FRAMES), .GAP_FRAMES(GAP_FRAMES),
    .LIM_SLOW(LIM_SLOW), .LIM_FAST(LIM_FAST)
  ) u_seq (
    .clk(clk), .rst(rst), .fast_mode(fast_mode),
    .phase(phase), .win_end(win_end), .wr_bank(wr_bank),
    .data_slot(data_slot), .lim(lim)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    side_buffer #(
      .STUB_W(STUB_W), .CW(CW), .PH_W(PH_W), .LIM_FAST(LIM_FAST)
    ) u_buf (
      .clk(clk), .rst(rst), .in_valid(in_v[s]), .in_stub(in_s[s]),
      .lim(lim), .win_end(win_end), .wr_bank(wr_bank), .phase(phase),
      .drop(drop[s]), .slot_hit(hit[s]), .stub_q(stub_q[s])
    );
    assign half_d[s] = (dslot_q && hit[s]) ? {1'b1, stub_q[s]} : '0;
  end

  drop_counter #(.N_IN(SIDES), .CNT_W(CNT_W)) u_drops (
    .clk(clk), .rst(rst), .drop(drop), .count(drop_count)
  );

  // Stage 1 aligns slot flags with the memory read; stage 2 is the output.
  always_ff @(posedge clk) begin
    if (rst) begin
      dslot_q     <= 1'b0;
      sop_q       <= 1'b0;
      frame_valid <= 1'b0;
      frame_sop   <= 1'b0;
      frame_data  <= '0;
    end else begin
      dslot_q     <= data_slot;
      sop_q       <= data_slot && (phase == '0);
      frame_valid <= dslot_q;
      frame_sop   <= sop_q;
      frame_data  <= {half_d[0], half_d[1]};
    end
  end

  // R3: start flag only on a data frame
  p_sop_valid_r3: assert property (@(posedge clk) disable iff (rst)
    frame_sop |-> frame_valid);

  // R3: start flag never on two frames in a row
  p_sop_single_r3: assert property (@(posedge clk) disable iff (rst)
    frame_sop |=> !frame_sop);

  // R2: gap frames carry nothing
  p_gap_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |-> (frame_data == '0));

  // R8: an empty upper half is all zero
  p_pad_hi_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_data[FRAME_W-1] |-> (frame_data[FRAME_W-2:HALF_W] == '0));

  // R8: an empty lower half is all zero
  p_pad_lo_r8: assert property (@(posedge clk) disable iff (rst)
    !frame_data[HALF_W-1] |-> (frame_data[HALF_W-2:0] == '0));

endmodule

// File: tb/sim_stub_pair_framer.sv
`timescale 1ns/1ps
module sim_stub_pair_framer;

  localparam int STUB_W = 31;
  localparam int CNT_W  = 6;
  localparam int NW     = 24;
  localparam int NWX    = NW + 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              fast_mode = 1'b0;
  logic              a_valid = 1'b0, b_valid = 1'b0;
  logic [STUB_W-1:0] a_stub = '0, b_stub = '0;
  logic              frame_valid, frame_sop;
  logic [63:0]       frame_data;
  logic [CNT_W-1:0]  drop_count;

  always #10 clk = ~clk;

  stub_pair_framer #(.STUB_W(STUB_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .fast_mode(fast_mode),
    .a_valid(a_valid), .a_stub(a_stub), .b_valid(b_valid), .b_stub(b_stub),
    .frame_valid(frame_valid), .frame_sop(frame_sop),
    .frame_data(frame_data), .drop_count(drop_count)
  );

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [STUB_W-1:0] exp_stub [NWX][2][64];
  int  exp_cnt [NWX][2];
  bit  win_fast [NWX];
  int  tgt [NWX][2];
  int  dens [NWX][2];
  int  cum_drop = 0;

  function automatic int lim_of(bit f);
    return f ? 35 : 16;
  endfunction

  function automatic logic [31:0] half_of(int pw, int f, int s);
    if (f < exp_cnt[pw][s]) return {1'b1, exp_stub[pw][s][f]};
    return '0;
  endfunction

  function automatic string tag_of(int pw, int f);
    if (f >= exp_cnt[pw][0] && f >= exp_cnt[pw][1]) return "R8";
    if (pw > 0 && win_fast[pw] != win_fast[pw-1]) return "R7";
    if (pw < 5) return win_fast[pw] ? "R6" : "R5";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string req, input int k,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", req, k, act, exp);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL R2 watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // Directed windows: limit edges, one-sided, empty, setting changes.
    win_fast[0] = 0; tgt[0][0] = 17; tgt[0][1] = 16;
    win_fast[1] = 1; tgt[1][0] = 36; tgt[1][1] = 35;
    win_fast[2] = 1; tgt[2][0] = 64; tgt[2][1] = 0;
    win_fast[3] = 0; tgt[3][0] = 0;  tgt[3][1] = 64;
    win_fast[4] = 0; tgt[4][0] = 0;  tgt[4][1] = 0;
    win_fast[5] = 1; tgt[5][0] = 64; tgt[5][1] = 64;
    for (int w = 0; w < 6; w++) begin
      dens[w][0] = 100; dens[w][1] = 100;
    end
    for (int w = 6; w < NWX; w++) begin
      win_fast[w] = (w < NW) ? 1'($urandom % 2) : 1'b0;
      for (int s = 0; s < 2; s++) begin
        tgt[w][s]  = (w < NW) ? 64 : 0;
        dens[w][s] = $urandom % 101;
      end
    end
    for (int w = 0; w < NWX; w++) begin
      exp_cnt[w][0] = 0; exp_cnt[w][1] = 0;
    end

    fast_mode = win_fast[0];
    repeat (3) @(negedge clk);

    for (int k = 0; k < 64 * NWX + 2; k++) begin
      int q, pw, f, w, ph;
      bit ev, es;
      logic [63:0] ed;
      logic [CNT_W-1:0] ec;
      logic v [2];
      logic [STUB_W-1:0] st [2];
      @(negedge clk);
      rst = 1'b0;

      // Outputs here reflect the state after rising edge k-1.
      q  = k - 2;
      ev = (q >= 64) && (q % 64 < 58);
      es = ev && (q % 64 == 0);
      pw = (q >= 64) ? q / 64 - 1 : 0;
      f  = (q >= 0) ? q % 64 : 0;
      ed = ev ? {half_of(pw, f, 0), half_of(pw, f, 1)} : 64'd0;
      ec = (cum_drop > 63) ? 6'd63 : CNT_W'(cum_drop);

      if (k == 0) begin
        chk(frame_valid == 0 && frame_sop == 0 && frame_data == 0 && drop_count == 0,
            "R10", k, {frame_valid, frame_sop, drop_count, frame_data[55:0]}, 64'd0);
      end
      chk(frame_valid == ev, (q < 64) ? "R10" : "R2", k, 64'(frame_valid), 64'(ev));
      chk(frame_sop == es, es ? "R11" : "R3", k, 64'(frame_sop), 64'(es));
      chk(frame_data == ed, ev ? tag_of(pw, f) : "R2", k, frame_data, ed);
      chk(drop_count == ec, "R9", k, 64'(drop_count), 64'(ec));
      if (ev && pw == 0 && f == 0) begin
        // R1: side A in the upper half, side B in the lower half
        chk(frame_data[63] == 1'b1 && frame_data[62:32] == exp_stub[0][0][0],
            "R1", k, frame_data, {1'b1, exp_stub[0][0][0], 1'b1, exp_stub[0][1][0]});
        chk(frame_data[31] == 1'b1 && frame_data[30:0] == exp_stub[0][1][0],
            "R1", k, frame_data, {1'b1, exp_stub[0][0][0], 1'b1, exp_stub[0][1][0]});
      end

      // Drive inputs sampled at rising edge k.
      w  = k / 64;
      ph = k % 64;
      fast_mode = ((k + 1) / 64 < NWX) ? win_fast[(k + 1) / 64] : 1'b0;
      for (int s = 0; s < 2; s++) begin
        v[s]  = (w < NWX) && (ph < tgt[w][s]) && (($urandom % 100) < dens[w][s]);
        st[s] = STUB_W'($urandom);
        if (v[s]) begin
          if (exp_cnt[w][s] < lim_of(win_fast[w])) begin
            exp_stub[w][s][exp_cnt[w][s]] = st[s];
            exp_cnt[w][s]++;
          end else begin
            cum_drop++;
          end
        end
      end
      a_valid = v[0]; a_stub = st[0];
      b_valid = v[1]; b_stub = st[1];
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule